// File: doc/BRIEF.md
# Programmable parallel I/O controller

This block is a general-purpose I/O controller for up to 32 pins, with the pin count set by a parameter. Each pin is driven either by software-programmed registers or by an on-chip peripheral that owns it. Per pin it offers an active-low pad output enable, an open-drain option, an input glitch filter, change-event capture, and a maskable interrupt. All of these are combined into one active-high request line.

Software reaches every control bit through register triplets on a simple peripheral bus slave. Writing a one to the set word sets the matching bits. Writing a one to the clear word clears them. The status word reads the result back. Two further read-only words return the pin levels and the pending change events. Reading the event word clears it.

Top module: `gpio_ctrl`

## Requirements
- R1: Under active-low `rst_n` every control register, the filter state and the event register are zero, so `pad_oe_n` is all ones, `pad_out` is zero and `irq` is low.
- R2: A write happens only when `bus_sel`, `bus_stb` and `bus_we` are all high. The word index is `bus_addr[13:2]`, and `bus_addr[1:0]` is ignored. Triplet t (0 peripheral-owner, 1 output enable, 2 output data, 3 filter enable, 4 interrupt mask, 5 open drain) has its set word at index 4t and its clear word at 4t+1. The update is visible from the next cycle.
- R3: The status word of triplet t at index 4t+2 reads the register combinationally, zero-extended to 32 bits. Writes to status or read-only indices change nothing.
- R4: When a pin's owner bit is 1, the pin drives the peripheral's data `per_in`, enabled when the active-low `per_oe_n` is 0.
- R5: When a pin's owner bit is 0, the pin drives the output-data bit, enabled by the output-enable bit.
- R6: With the open-drain bit set, `pad_out` is 0 and `pad_oe_n` is low only while the selected enable is on and the selected data is 0. Otherwise the pin is released.
- R7: `per_out` always equals `pad_in` combinationally, whatever the pin's mode.
- R8: The input is registered once into a sample. The filtered value takes the new pad level at a clock edge only where `pad_in` equals the sample, which means two equal consecutive samples. A pulse of one clock is therefore never seen.
- R9: The pin level (word index 24) is the filtered value where the filter bit is set and the registered sample elsewhere. A change of the level from its value in the previous cycle sets the event bit at the next edge.
- R10: The event word (index 25) clears all its bits at the edge that ends a read of it. An event recorded at that same edge stays set.
- R11: `irq` is high exactly when some event bit is set whose mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Block select |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | AW (14) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request, active high |
| pad_in | input | NLINES | Levels from the pads |
| pad_out | output | NLINES | Data to the pads |
| pad_oe_n | output | NLINES | Pad output enable, active low |
| per_in | input | NLINES | Data from the owning peripheral |
| per_oe_n | input | NLINES | Peripheral enable, active low |
| per_out | output | NLINES | Pad levels forwarded to peripherals |

## Verification
Clearing the event word by a read and recording a new pin change can fall on the same clock edge. The bench provokes this by changing `pad_in` one cycle before it reads the event word, so the level change reaches event capture exactly at the read's closing edge. The reference model takes the bits from that edge as kept and all older bits as cleared. The following reads and `irq` are compared against it.

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int NLINES = 32,
  parameter int AW     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe_n,
  input  logic [NLINES-1:0] per_in,
  input  logic [NLINES-1:0] per_oe_n,
  output logic [NLINES-1:0] per_out
);
  localparam int IW    = AW - 2;
  localparam int NTRI  = 6;
  localparam int T_PER = 0;
  localparam int T_OE  = 1;
  localparam int T_DAT = 2;
  localparam int T_FLT = 3;
  localparam int T_MSK = 4;
  localparam int T_OD  = 5;
  localparam logic [IW-1:0] IDX_LVL = IW'(24);
  localparam logic [IW-1:0] IDX_EVT = IW'(25);

  logic [NTRI-1:0][NLINES-1:0] cfg;
  logic [NLINES-1:0] samp, flt, lvl, lvl_q, evt, chg, wd, stab, sel_d, sel_oe;

  wire [IW-1:0] idx    = bus_addr[AW-1:2];
  wire          acc    = bus_sel & bus_stb;
  wire          wr     = acc & bus_we;
  wire          rd_evt = acc & ~bus_we & (idx == IDX_EVT);
  wire          unused_addr_lo = ^bus_addr[1:0];

  assign wd = bus_wdata[NLINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      for (int t = 0; t < NTRI; t++) begin
        if (wr && idx == IW'(4*t))
          cfg[t] <= cfg[t] | wd;
        else if (wr && idx == IW'(4*t+1))
          cfg[t] <= cfg[t] & ~wd;
      end
    end
  end

  assign stab = ~(pad_in ^ samp);
  assign lvl  = (cfg[T_FLT] & flt) | (~cfg[T_FLT] & samp);
  assign chg  = lvl ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp  <= '0;
      flt   <= '0;
      lvl_q <= '0;
      evt   <= '0;
    end else begin
      samp  <= pad_in;
      flt   <= (stab & pad_in) | (~stab & flt);
      lvl_q <= lvl;
      evt   <= (rd_evt ? '0 : evt) | chg;
    end
  end

  assign irq = |(evt & cfg[T_MSK]);

  assign sel_d    = (cfg[T_PER] & per_in) | (~cfg[T_PER] & cfg[T_DAT]);
  assign sel_oe   = (cfg[T_PER] & ~per_oe_n) | (~cfg[T_PER] & cfg[T_OE]);
  assign pad_out  = sel_d & ~cfg[T_OD];
  assign pad_oe_n = ~(sel_oe & ~(cfg[T_OD] & sel_d));
  assign per_out  = pad_in;

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NTRI; t++)
      if (idx == IW'(4*t+2)) bus_rdata[NLINES-1:0] = cfg[t];
    if (idx == IDX_LVL) bus_rdata[NLINES-1:0] = lvl;
    if (idx == IDX_EVT) bus_rdata[NLINES-1:0] = evt;
  end

  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IW'(4*T_OE)) |=> (($past(wd) & ~cfg[T_OE]) == '0));

  a_r6_od_never_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pad_oe_n) & pad_out & cfg[T_OD]) == '0);

  a_r8_filter_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flt ^ $past(flt)) & ($past(pad_in) ^ $past(samp))) == '0));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> ((evt & ~$past(chg)) == '0));

  a_r10_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(chg) & ~evt) == '0));

  a_r11_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt != '0));
endmodule

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic sel = 0, stb = 0, we = 0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe_n, per_in = '0, per_oe_n = '1, per_out;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_ctrl i_gpio_ctrl (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_stb(stb), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe_n(pad_oe_n), .per_in(per_in), .per_oe_n(per_oe_n), .per_out(per_out));

  logic [N-1:0] m_reg [6];
  logic [N-1:0] m_samp, m_flt, m_lvq, m_ev;

  function automatic logic [N-1:0] m_level();
    logic [N-1:0] l;
    for (int i = 0; i < N; i++) l[i] = m_reg[3][i] ? m_flt[i] : m_samp[i];
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < 6; t++) m_reg[t] = '0;
      m_samp = '0; m_flt = '0; m_lvq = '0; m_ev = '0;
    end else begin
      automatic logic [N-1:0] l = m_level();
      automatic int ix = int'(addr[13:2]);
      if (sel && stb && !we && ix == 25) m_ev = '0;
      m_ev = m_ev | (l ^ m_lvq);
      m_lvq = l;
      for (int i = 0; i < N; i++) if (pad_in[i] == m_samp[i]) m_flt[i] = pad_in[i];
      m_samp = pad_in;
      if (sel && stb && we && ix < 24) begin
        if (ix % 4 == 0) m_reg[ix/4] = m_reg[ix/4] | wdata;
        else if (ix % 4 == 1) m_reg[ix/4] = m_reg[ix/4] & ~wdata;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    automatic logic [N-1:0] po, pe;
    automatic int ix = int'(addr[13:2]);
    for (int i = 0; i < N; i++) begin
      automatic logic sd = m_reg[0][i] ? per_in[i] : m_reg[2][i];
      automatic logic se = m_reg[0][i] ? !per_oe_n[i] : m_reg[1][i];
      if (m_reg[5][i]) begin po[i] = 1'b0; pe[i] = !(se && !sd); end
      else begin po[i] = sd; pe[i] = !se; end
    end
    check("R4 pad_out", pad_out, po);
    check("R6 pad_oe_n", pad_oe_n, pe);
    check("R7 per_out", per_out, pad_in);
    check("R11 irq", {31'b0, irq}, {31'b0, |(m_ev & m_reg[4])});
    if (sel && stb && !we) begin
      if (ix == 24) check("R9 level", rdata, m_level());
      else if (ix == 25) check("R10 events", rdata, m_ev);
      else if (ix < 24 && ix % 4 == 2) check("R3 status", rdata, m_reg[ix/4]);
      else check("R3 unmapped", rdata, 32'h0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic wr(int ix, logic [31:0] d, logic [1:0] lo = 2'b00);
    sel = 1; stb = 1; we = 1; addr = {12'(ix), lo}; wdata = d;
    step();
    sel = 0; stb = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(int ix);
    sel = 1; stb = 1; we = 0; addr = {12'(ix), 2'b00};
    step();
    sel = 0; stb = 0;
  endtask

  initial begin
    step(2);
    check("R1 reset oe_n", pad_oe_n, '1);
    check("R1 reset out", pad_out, '0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1;
    step();
    // R2: set, clear, ignored low address bits, unqualified write
    wr(4, 32'h0000_FFFF, 2'b11);
    wr(8, 32'hA5A5_00FF);
    wr(9, 32'h0000_000F, 2'b01);
    sel = 0; stb = 1; we = 1; addr = 14'(5 << 2); wdata = '1; step(); stb = 0; we = 0;
    sel = 1; stb = 0; we = 1; addr = 14'(5 << 2); wdata = '1; step(); sel = 0; we = 0;
    addr = 14'(6 << 2); sel = 1; stb = 1; #1;
    check("R2 oe status", rdata, 32'h0000_FFFF);
    step(); sel = 0; stb = 0;
    rd(10);
    // R3: writes to status and read-only words ignored
    wr(6, '1); wr(24, '1); wr(25, '1); wr(30, '1);
    rd(6); rd(30);
    #1 check("R5 sw drive", pad_out, 32'hA5A5_00F0);
    // R4: peripheral ownership
    per_in = 32'h1234_5678; per_oe_n = 32'h00FF_00FF;
    wr(0, 32'hFF00_FF00);
    step(2);
    per_in = 32'hFFFF_0000; per_oe_n = 32'h0F0F_0F0F; step(2);
    // R6: open drain on mixed ownership
    wr(20, 32'h3C3C_3C3C);
    step(2);
    wr(1, '1); step();
    wr(21, '1); wr(2, 32'hF0F0_F0F0);
    // R8, R9: glitch and level
    wr(16, 32'h0000_00FF);
    wr(12, 32'h0000_000F);
    rd(25);
    pad_in = 32'h0000_00FF; step();
    pad_in = '0; step(3);
    rd(24);
    #1 check("R8 glitch hidden", {31'b0, irq}, 32'h1);
    rd(25);
    pad_in = 32'h0000_000F; step(4);
    addr = 14'(24 << 2); sel = 1; stb = 1; #1;
    check("R8 filtered level", rdata, 32'h0000_000F);
    step(); sel = 0; stb = 0;
    rd(25);
    // R10: event on the read's closing edge is kept
    pad_in = 32'h0000_00F0; step();
    rd(25);
    rd(25);
    rd(25);
    for (int k = 0; k < 400; k++) begin
      pad_in = $urandom; per_in = $urandom; per_oe_n = $urandom;
      case ($urandom % 6)
        0: wr(($urandom % 6) * 4 + ($urandom % 2), $urandom);
        1: rd(25);
        2: rd(24);
        3: rd(($urandom % 6) * 4 + 2);
        default: step();
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule